// File: doc/BRIEF.md
# Floppy Head Stepper Phase Tracker

This block follows the position of a floppy drive read head that is moved by a four-coil stepper motor. The host steers the motor by touching soft-switch addresses. Each access names one coil and whether that coil is switched on or off. The block keeps the head position in half-track units. It also keeps the coil that was most recently switched on. When a coil is switched on, the block looks up the move in a table indexed by the previous coil and the new coil, and applies it to the position. The position is held within the physical range of the drive.

The block presents the half-track position and the whole-track number derived from it. Whenever the whole-track number changes, it raises a one-cycle pulse so that a downstream track buffer knows to reload its contents. Switch-off accesses are accepted on the same bus but never move the head.

Top module: `head_stepper_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, the half-track position and the track become 0, `track_step` becomes 0, and the remembered coil becomes coil 0. An energize of coil 1 right after reset therefore moves the head to half-track 1.
- R2: An access is sampled when `acc_valid` is high at a rising clock edge. `acc_addr[2:1]` selects coil 0..3 and `acc_addr[0]` is 1 to switch the coil on and 0 to switch it off.
- R3: A switch-off access leaves the position and the remembered coil unchanged.
- R4: Switching on the coil one above the remembered coil (modulo 4) adds one half-track.
- R5: Switching on the coil one below the remembered coil (modulo 4) subtracts one half-track.
- R6: Switching on the remembered coil again, or the coil opposite it (difference 2), leaves the position unchanged. In every switch-on case the new coil becomes the remembered coil.
- R7: The position never leaves 0..69. A step below 0 or above 69 is dropped, and the coil is still remembered.
- R8: `track` always equals the half-track position divided by two (rounded down), in the range 0..34.
- R9: `track_step` is high for exactly the one cycle in which a new track value first appears, and it is low at all other times.
- R10: Position changes become visible on the clock edge that samples the access. With no access, the position holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Soft-switch access strobe |
| acc_addr | input | 3 | Coil select in bits 2:1, on/off in bit 0 |
| half_track | output | 7 | Head position in half-tracks, 0..69 |
| track | output | 6 | Whole track, half_track / 2 |
| track_step | output | 1 | One-cycle pulse when the track changes |

## Verification
The head is first driven by a rising coil sequence from one end of the range to the other, and then by a falling sequence back again. These two sweeps separate the step directions and check the stops at 0 and at 69. An exhaustive pass then covers every previous-coil and new-coil pair, with switch-off accesses to all four coils placed in between. This shows whether the table is correct for all sixteen cells and whether switch-off accesses are truly ignored, including their effect on the remembered coil. Reset is applied again in the middle of the run, followed by moves toward coil 3 and coil 1. This separates a remembered coil of 0 from any stale value left over from before the reset.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

    localparam int PHASE_CNT = 4;
    localparam int PHASE_W   = 2;

    typedef logic [PHASE_W-1:0] phase_t;

    typedef enum logic [1:0] {
        MV_HOLD    = 2'd0,
        MV_INWARD  = 2'd1,
        MV_OUTWARD = 2'd2
    } move_e;

    typedef struct packed {
        logic   valid;
        logic   energize;
        phase_t phase;
    } coil_cmd_t;

    // Neighbour above moves in, neighbour below moves out; same or opposite holds.
    function automatic move_e phase_move(phase_t prev, phase_t nxt);
        phase_t diff;
        diff = nxt - prev;
        case (diff)
            2'd1:    return MV_INWARD;
            2'd3:    return MV_OUTWARD;
            default: return MV_HOLD;
        endcase
    endfunction

endpackage

// File: rtl/coil_decode.sv
module coil_decode
    import stepper_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    output coil_cmd_t         cmd
);
    // Bit 0 chooses on/off, the bits above choose the coil (R2).
    always_comb begin
        cmd.valid    = acc_valid;
        cmd.energize = acc_addr[0];
        cmd.phase    = acc_addr[PHASE_W:1];
    end
endmodule

// File: rtl/stepper_move_table.sv
module stepper_move_table
    import stepper_pkg::*;
(
    input  phase_t prev_phase,
    input  phase_t new_phase,
    output move_e  move
);
    localparam int CELLS = PHASE_CNT * PHASE_CNT;

    move_e table_q [CELLS];

    genvar gp, gn;
    generate
        for (gp = 0; gp < PHASE_CNT; gp++) begin : g_prev
            for (gn = 0; gn < PHASE_CNT; gn++) begin : g_new
                assign table_q[gp*PHASE_CNT + gn] =
                    phase_move(phase_t'(gp), phase_t'(gn));
            end
        end
    endgenerate

    assign move = table_q[{prev_phase, new_phase}];
endmodule

// File: rtl/stepper_position.sv
module stepper_position
    import stepper_pkg::*;
#(
    parameter int MAX_HALF = 69,
    parameter int POS_W    = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  coil_cmd_t        cmd,
    input  move_e            move,
    output logic [POS_W-1:0] pos,
    output phase_t           last_phase,
    output logic             track_pulse
);
    logic [POS_W-1:0] next_pos;
    logic             do_energize;

    assign do_energize = cmd.valid && cmd.energize;

    always_comb begin
        next_pos = pos;
        if (do_energize) begin
            case (move)
                MV_INWARD:  if (pos < POS_W'(MAX_HALF)) next_pos = pos + 1'b1;
                MV_OUTWARD: if (pos != '0)              next_pos = pos - 1'b1;
                default:    next_pos = pos;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos         <= '0;
            last_phase  <= '0;
            track_pulse <= 1'b0;
        end else begin
            pos         <= next_pos;
            track_pulse <= (next_pos[POS_W-1:1] != pos[POS_W-1:1]);
            if (do_energize)
                last_phase <= cmd.phase;
        end
    end
endmodule

// File: rtl/head_stepper_tracker.sv
module head_stepper_tracker
    import stepper_pkg::*;
#(
    parameter int MAX_HALF = 69,
    parameter int ADDR_W   = 3,
    localparam int POS_W   = $clog2(MAX_HALF + 1),
    localparam int TRK_W   = POS_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [POS_W-1:0]  half_track,
    output logic [TRK_W-1:0]  track,
    output logic              track_step
);
    coil_cmd_t cmd;
    move_e     move;
    phase_t    last_phase;

    coil_decode #(.ADDR_W(ADDR_W)) u_decode (
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .cmd       (cmd)
    );

    stepper_move_table u_table (
        .prev_phase (last_phase),
        .new_phase  (cmd.phase),
        .move       (move)
    );

    stepper_position #(.MAX_HALF(MAX_HALF), .POS_W(POS_W)) u_pos (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .move        (move),
        .pos         (half_track),
        .last_phase  (last_phase),
        .track_pulse (track_step)
    );

    assign track = half_track[POS_W-1:1];
endmodule

// File: rtl/head_stepper_checker.sv
module head_stepper_checker #(
    parameter int MAX_HALF = 69,
    parameter int ADDR_W   = 3,
    parameter int POS_W    = 7,
    parameter int TRK_W    = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [POS_W-1:0]  half_track,
    input logic [TRK_W-1:0]  track,
    input logic              track_step
);
    p_range_r7: assert property (@(posedge clk) disable iff (rst)
        int'(half_track) <= MAX_HALF);

    p_off_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_addr[0]) |=> $stable(half_track));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> $stable(half_track));

    p_one_step_r4: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> (int'(half_track) - int'($past(half_track)) <= 1 &&
                       int'($past(half_track)) - int'(half_track) <= 1));

    p_pulse_on_change_r9: assert property (@(posedge clk) disable iff (rst)
        (track != $past(track)) |-> track_step);

    p_pulse_only_change_r9: assert property (@(posedge clk) disable iff (rst)
        track_step |-> (track != $past(track)));
endmodule

bind head_stepper_tracker head_stepper_checker #(
    .MAX_HALF (MAX_HALF),
    .ADDR_W   (ADDR_W),
    .POS_W    (POS_W),
    .TRK_W    (TRK_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .half_track (half_track),
    .track      (track),
    .track_step (track_step)
);

// File: tb/head_stepper_tracker_test.sv
module head_stepper_tracker_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       acc_valid;
    logic [2:0] acc_addr;
    logic [6:0] half_track;
    logic [5:0] track;
    logic       track_step;

    int checks = 0;
    int errors = 0;
    int ref_pos;
    int ref_last;

    always #10 clk = ~clk;

    head_stepper_tracker uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .half_track(half_track), .track(track), .track_step(track_step)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_outputs(string req, int exp_pulse);
        chk(req, int'(half_track), ref_pos);
        chk("R8", int'(track), ref_pos / 2);
        chk("R9", int'(track_step), exp_pulse);
    endtask

    // Called at a negedge; samples results at the following negedge (R10).
    task automatic access(int ph, int on);
        int    old_pos;
        int    d;
        string req;
        old_pos   = ref_pos;
        acc_valid = 1'b1;
        acc_addr  = {ph[1:0], on[0]};   // R2 encoding
        @(negedge clk);
        acc_valid = 1'b0;
        if (on != 0) begin
            d = (ph - ref_last + 4) % 4;
            if (d == 1) begin
                req = "R4";
                if (ref_pos < 69) ref_pos++; else req = "R7";
            end else if (d == 3) begin
                req = "R5";
                if (ref_pos > 0) ref_pos--; else req = "R7";
            end else begin
                req = "R6";
            end
            ref_last = ph;
        end else begin
            req = "R3";
        end
        check_outputs(req, (ref_pos / 2 != old_pos / 2) ? 1 : 0);
    endtask

    task automatic idle();
        @(negedge clk);
        check_outputs("R10", 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        acc_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        ref_pos  = 0;
        ref_last = 0;
        check_outputs("R1", 0);
    endtask

    initial begin
        rst = 1'b1;
        acc_valid = 1'b0;
        acc_addr = '0;
        ref_pos = 0;
        ref_last = 0;
        do_reset();
        // R1: remembered coil is 0, so coil 1 steps in.
        access(1, 1);
        chk("R1", int'(half_track), 1);
        access(0, 1);
        access(3, 1);          // below 0: dropped (R7)
        idle();
        // Rising sweep to the top stop (R4, R7).
        for (int i = 0; i < 80; i++) access((ref_last + 1) % 4, 1);
        chk("R7", int'(half_track), 69);
        idle();
        // Falling sweep to the bottom stop (R5, R7).
        for (int i = 0; i < 80; i++) access((ref_last + 3) % 4, 1);
        chk("R7", int'(half_track), 0);
        for (int i = 0; i < 20; i++) access((ref_last + 1) % 4, 1);
        // Exhaustive table pass with switch-off accesses between (R3, R6).
        for (int p = 0; p < 4; p++) begin
            for (int n = 0; n < 4; n++) begin
                access(p, 1);
                for (int o = 0; o < 4; o++) access(o, 0);
                access(n, 1);
                idle();
            end
        end
        // Reset mid-run clears the remembered coil.
        for (int i = 0; i < 5; i++) access((ref_last + 1) % 4, 1);
        access(2, 1);
        do_reset();
        access(3, 1);
        access(1, 1);
        access(2, 1);
        idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule